// File: doc/BRIEF.md
# Crossroad Signal Phase Controller

This block sequences the lamps at a junction where a busy main road meets a lightly used side road. The main road shows green by default. It gives way only when a vehicle sensor on the side road reports a waiting car and the main green has run for at least a long interval. Each change of right of way passes through a yellow phase of a short interval. The side road then keeps green while a car is still sensed, but never for longer than the long interval. After its own yellow, control returns to the main road.

The controller contains its own restartable interval timer. Every phase change pulses a restart output for one cycle. That pulse clears the timer, so each phase measures its dwell from zero. The two intervals are parameters given in clock cycles, and the phase register can be built binary or one-hot. The sensor input is used as delivered, with no filtering.

Top module: `xroad_light_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the lamps show main green and side red and `tmr_restart` is low, whatever `side_car` is.
- R2: In every cycle exactly one of each road's three lamps is lit. `main_red` is lit exactly when the side road shows green or yellow, and `side_red` is lit exactly when the main road shows green or yellow.
- R3: Main green lasts at least LONG_CYC+1 cycles, counted from its first cycle after reset or after side yellow. It stays green indefinitely while `side_car` is low.
- R4: In main green, `tmr_restart` is high in a cycle exactly when `side_car` is high and at least LONG_CYC cycles of main green have already passed. Main yellow follows at the next edge.
- R5: Main yellow lasts exactly SHORT_CYC+1 cycles. `tmr_restart` is high in its last cycle, and side green follows.
- R6: Side green ends with `tmr_restart` high in the first cycle in which `side_car` is low, or in its (LONG_CYC+1)-th cycle, whichever comes first. Side yellow follows.
- R7: Side yellow lasts exactly SHORT_CYC+1 cycles, then main green returns with `tmr_restart` high in its last cycle.
- R8: The lamp outputs change at an edge only if `tmr_restart` was high in the cycle before that edge, and they always change in that case.
- R9: The interval-expired condition holds after expiry until the next restart. A car that first appears long after the minimum main green has passed causes `tmr_restart` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| side_car | input | 1 | High while a vehicle waits on the side road |
| main_grn | output | 1 | Main road green lamp |
| main_yel | output | 1 | Main road yellow lamp |
| main_red | output | 1 | Main road red lamp |
| side_grn | output | 1 | Side road green lamp |
| side_yel | output | 1 | Side road yellow lamp |
| side_red | output | 1 | Side road red lamp |
| tmr_restart | output | 1 | One-cycle pulse in the cycle before each phase change; clears the interval timer |

## Verification
The bench aims at the exact dwell boundaries. A timer that is off by one would hand over main green a cycle early or late, or hold a yellow phase for SHORT_CYC or SHORT_CYC+2 cycles. It covers a car that arrives long after the minimum green: a design whose expiry flag pulses instead of holding would then leave the car stranded in main green. It also covers a side car that leaves in the first side-green cycle, and one that stays past the cap. A controller that ignored the sensor would overrun side green in the first case, and one that ignored the cap would never yield in the second. Random sensor traffic with short and long bursts then compares every lamp and restart value against a phase model kept in the bench.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

   typedef enum logic [1:0] {
      PH_MAIN_GO   = 2'd0,
      PH_MAIN_WARN = 2'd1,
      PH_SIDE_GO   = 2'd2,
      PH_SIDE_WARN = 2'd3
   } phase_e;

   typedef struct packed {
      logic grn;
      logic yel;
      logic red;
   } lamp_t;

   localparam int unsigned NUM_PHASES = 4;

endpackage

// File: rtl/xroad_interval_timer.sv
module xroad_interval_timer #(
   parameter int unsigned SHORT_CYC = 3,
   parameter int unsigned LONG_CYC  = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic short_done,
   output logic long_done
);
   localparam int unsigned CW = $clog2(LONG_CYC + 1);
   localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
   localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

   logic [CW-1:0] cnt_q;

   // saturating dwell counter; the flags stay up until the next restart
   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt_q <= '0;
      end else if (cnt_q != LONG_V) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign short_done = (cnt_q >= SHORT_V);
   assign long_done  = (cnt_q == LONG_V);

endmodule

// File: rtl/xroad_phase_fsm.sv
module xroad_phase_fsm
   import xroad_pkg::*;
#(
   parameter bit ONE_HOT_STATE = 1'b1
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   car,
   input  logic   short_done,
   input  logic   long_done,
   output phase_e phase,
   output logic   advance
);

   always_comb begin
      unique case (phase)
         PH_MAIN_GO:   advance = long_done & car;
         PH_MAIN_WARN: advance = short_done;
         PH_SIDE_GO:   advance = long_done | ~car;
         PH_SIDE_WARN: advance = short_done;
         default:      advance = 1'b0;
      endcase
   end

   generate
      if (ONE_HOT_STATE) begin : g_onehot
         logic [NUM_PHASES-1:0] hot_q;

         // the single set bit rotates forward on each phase change
         always_ff @(posedge clk) begin
            if (rst) begin
               hot_q <= NUM_PHASES'(1);
            end else if (advance) begin
               hot_q <= {hot_q[NUM_PHASES-2:0], hot_q[NUM_PHASES-1]};
            end
         end

         always_comb begin
            phase = PH_MAIN_GO;
            if (hot_q[1]) phase = PH_MAIN_WARN;
            if (hot_q[2]) phase = PH_SIDE_GO;
            if (hot_q[3]) phase = PH_SIDE_WARN;
         end
      end else begin : g_binary
         phase_e ph_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               ph_q <= PH_MAIN_GO;
            end else if (advance) begin
               ph_q <= phase_e'(ph_q + 2'd1);
            end
         end

         assign phase = ph_q;
      end
   endgenerate

endmodule

// File: rtl/xroad_lamp_map.sv
module xroad_lamp_map
   import xroad_pkg::*;
(
   input  phase_e phase,
   output lamp_t  main_l,
   output lamp_t  side_l
);
   logic main_has_way;

   assign main_has_way = (phase == PH_MAIN_GO) || (phase == PH_MAIN_WARN);

   always_comb begin
      main_l.grn = (phase == PH_MAIN_GO);
      main_l.yel = (phase == PH_MAIN_WARN);
      main_l.red = ~main_has_way;
      side_l.grn = (phase == PH_SIDE_GO);
      side_l.yel = (phase == PH_SIDE_WARN);
      side_l.red = main_has_way;
   end

endmodule

// File: rtl/xroad_light_ctrl.sv
module xroad_light_ctrl
   import xroad_pkg::*;
#(
   parameter int unsigned SHORT_CYC     = 3,
   parameter int unsigned LONG_CYC      = 8,
   parameter bit          ONE_HOT_STATE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic side_car,
   output logic main_grn,
   output logic main_yel,
   output logic main_red,
   output logic side_grn,
   output logic side_yel,
   output logic side_red,
   output logic tmr_restart
);

   generate
      if (SHORT_CYC < 1 || LONG_CYC <= SHORT_CYC) begin : g_bad_intervals
         initial $fatal(1, "xroad_light_ctrl: need 1 <= SHORT_CYC < LONG_CYC");
      end
   endgenerate

   phase_e phase;
   lamp_t  main_l;
   lamp_t  side_l;
   logic   short_done;
   logic   long_done;
   logic   advance;

   xroad_interval_timer #(
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .restart    (advance),
      .short_done (short_done),
      .long_done  (long_done)
   );

   xroad_phase_fsm #(
      .ONE_HOT_STATE (ONE_HOT_STATE)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .car        (side_car),
      .short_done (short_done),
      .long_done  (long_done),
      .phase      (phase),
      .advance    (advance)
   );

   xroad_lamp_map u_lamps (
      .phase  (phase),
      .main_l (main_l),
      .side_l (side_l)
   );

   assign main_grn    = main_l.grn;
   assign main_yel    = main_l.yel;
   assign main_red    = main_l.red;
   assign side_grn    = side_l.grn;
   assign side_yel    = side_l.yel;
   assign side_red    = side_l.red;
   assign tmr_restart = advance;

endmodule

// File: rtl/xroad_light_ctrl_chk.sv
module xroad_light_ctrl_chk #(
   parameter int unsigned LONG_CYC = 8
) (
   input logic clk,
   input logic rst,
   input logic side_car,
   input logic main_grn,
   input logic main_yel,
   input logic main_red,
   input logic side_grn,
   input logic side_yel,
   input logic side_red,
   input logic tmr_restart
);
   localparam int unsigned HW = $clog2(LONG_CYC + 2);

   logic [HW-1:0] green_run;
   logic [5:0]    lamps;

   assign lamps = {main_grn, main_yel, main_red, side_grn, side_yel, side_red};

   always_ff @(posedge clk) begin
      if (rst || !main_grn) begin
         green_run <= '0;
      end else if (green_run <= HW'(LONG_CYC)) begin
         green_run <= green_run + 1'b1;
      end
   end

   // R2
   main_one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({main_grn, main_yel, main_red}) == 1);

   // R2
   side_one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({side_grn, side_yel, side_red}) == 1 && (main_red == (side_grn | side_yel)));

   // R3
   min_green_chk: assert property (@(posedge clk) disable iff (rst)
      (main_grn && tmr_restart) |-> (green_run >= HW'(LONG_CYC)));

   // R4
   no_yield_without_car_chk: assert property (@(posedge clk) disable iff (rst)
      (main_grn && !side_car) |-> !tmr_restart);

   // R5
   main_warn_to_side_chk: assert property (@(posedge clk) disable iff (rst)
      (main_yel && tmr_restart) |=> side_grn);

   // R6
   side_empty_ends_chk: assert property (@(posedge clk) disable iff (rst)
      (side_grn && !side_car) |-> tmr_restart);

   // R7
   side_warn_to_main_chk: assert property (@(posedge clk) disable iff (rst)
      (side_yel && tmr_restart) |=> main_grn);

   // R8
   hold_lamps_chk: assert property (@(posedge clk) disable iff (rst)
      !tmr_restart |=> $stable(lamps));

   // R8
   change_lamps_chk: assert property (@(posedge clk) disable iff (rst)
      tmr_restart |=> !$stable(lamps));

endmodule

bind xroad_light_ctrl xroad_light_ctrl_chk #(.LONG_CYC(LONG_CYC)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .side_car    (side_car),
   .main_grn    (main_grn),
   .main_yel    (main_yel),
   .main_red    (main_red),
   .side_grn    (side_grn),
   .side_yel    (side_yel),
   .side_red    (side_red),
   .tmr_restart (tmr_restart)
);

// File: tb/xroad_light_ctrl_tb_top.sv
module xroad_light_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SHORT_C    = 3;
   localparam int LONG_C     = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic side_car = 1'b0;
   logic main_grn, main_yel, main_red, side_grn, side_yel, side_red, tmr_restart;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model of the requirements
   int mph   = 0;
   int dwell = 0;
   int obs_green = 0;
   logic [5:0] prev_lamps;
   logic       prev_restart = 1'b0;
   bit         have_prev    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xroad_light_ctrl #(
      .SHORT_CYC (SHORT_C),
      .LONG_CYC  (LONG_C)
   ) dut_i (
      .clk         (clk),
      .rst         (rst),
      .side_car    (side_car),
      .main_grn    (main_grn),
      .main_yel    (main_yel),
      .main_red    (main_red),
      .side_grn    (side_grn),
      .side_yel    (side_yel),
      .side_red    (side_red),
      .tmr_restart (tmr_restart)
   );

   function automatic logic [5:0] exp_lamps(input int ph);
      case (ph)
         0: return 6'b100_001;
         1: return 6'b010_001;
         2: return 6'b001_100;
         default: return 6'b001_010;
      endcase
   endfunction

   function automatic logic exp_go(input int ph, input int dw, input logic car);
      case (ph)
         0: return (dw >= LONG_C) && car;
         1: return dw >= SHORT_C;
         2: return (dw >= LONG_C) || !car;
         default: return dw >= SHORT_C;
      endcase
   endfunction

   function automatic string go_tag(input int ph);
      case (ph)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic logic [5:0] cur_lamps();
      return {main_grn, main_yel, main_red, side_grn, side_yel, side_red};
   endfunction

   // one cycle: drive, check away from the edge, advance model, wait
   task automatic step(input logic car);
      logic go;
      side_car = car;
      #1;
      go = exp_go(mph, dwell, car);
      check("R2", 32'(cur_lamps()), 32'(exp_lamps(mph)));
      check("R2", 32'($countones({main_grn, main_yel, main_red}) == 1 &&
                       $countones({side_grn, side_yel, side_red}) == 1), 32'd1);
      check(go_tag(mph), 32'(tmr_restart), 32'(go));
      if (have_prev && !prev_restart)
         check("R8", 32'(cur_lamps()), 32'(prev_lamps));
      if (have_prev && prev_restart)
         check("R8", 32'(cur_lamps() != prev_lamps), 32'd1);
      if (main_grn && tmr_restart)
         check("R3", 32'(obs_green >= LONG_C), 32'd1);
      obs_green    = main_grn ? obs_green + 1 : 0;
      prev_lamps   = cur_lamps();
      prev_restart = tmr_restart;
      have_prev    = 1'b1;
      if (go) begin
         mph   = (mph + 1) % 4;
         dwell = 0;
      end else if (dwell < 1000) begin
         dwell++;
      end
      @(negedge clk);
   endtask

   task automatic run(input logic car, input int n);
      for (int i = 0; i < n; i++) step(car);
   endtask

   task automatic run_to_phase(input int ph, input logic car);
      for (int i = 0; i < 100 && mph != ph; i++) step(car);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state, car present
      side_car = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         check("R1", 32'(cur_lamps()), 32'(6'b100_001));
         check("R1", 32'(tmr_restart), 32'd0);
      end
      rst = 1'b0;
      #1;
      check("R1", 32'(tmr_restart), 32'd0);
      check("R1", 32'(cur_lamps()), 32'(6'b100_001));

      // R3: no car, main green holds
      run(1'b0, 25);
      check("R3", 32'(main_grn), 32'd1);

      // R9: late car causes restart in the same cycle
      side_car = 1'b1;
      #1;
      check("R9", 32'(tmr_restart), 32'd1);
      step(1'b1);

      // R5, R6: car held through side green, cap ends it
      run_to_phase(2, 1'b1);
      run(1'b1, LONG_C + 1);
      check("R6", 32'(side_yel), 32'd1);

      // R7: back to main green; car keeps waiting, R4 min green
      run_to_phase(0, 1'b1);
      run_to_phase(2, 1'b1);
      // R6: car leaves in first side-green cycle
      step(1'b0);
      check("R6", 32'(side_yel), 32'd1);
      run_to_phase(0, 1'b0);

      // random sensor traffic in bursts
      for (int b = 0; b < 400; b++) begin
         logic c = 1'($urandom % 2);
         int   len = (($urandom % 3) == 0) ? int'($urandom % 20) + 1 : int'($urandom % 4) + 1;
         run(c, len);
      end

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule